// File: doc/BRIEF.md
# PWM Latch with Non-Overlap Gate Drive

This block is the switching latch of a voltage-mode synchronous buck controller. A one-cycle switching-clock pulse starts each power cycle, and a pulse from the PWM comparator ends it. The block turns these two events into complementary gate-enable levels for the high-side and low-side switches. Every change from one switch to the other passes through a dead interval of `DEAD_CYC` system-clock cycles, during which both enables are low. This means the two switches never conduct at the same time.

The block has no ramp, no comparator and no driver stage. Its inputs are already-digitised events in the system clock domain. The switching pulse comes from an external divider that runs at either 300 kHz or 600 kHz. A shared package function gives the number of system-clock cycles in one switching period for each of the two rates. A fault input, or removal of the enable, parks both switches off. Switching restarts only after the fault or disable condition is gone and a new switching pulse arrives.

Top module: `pwm_nonoverlap_drv`

## Requirements
- R1: After synchronous reset, and until the first switching pulse is accepted, `hs_en` and `ls_en` are both 0.
- R2: A switching pulse sampled while the block is idle or in the low-side phase turns `ls_en` off at that clock edge. `hs_en` then rises at the `DEAD_CYC`-th following edge.
- R3: A comparator trip sampled while `hs_en` is 1 drives `hs_en` to 0 at that same edge. Without a trip, a switching pulse or a halt, `hs_en` stays 1.
- R4: After a trip has turned the high side off, `ls_en` rises after exactly `DEAD_CYC` cycles in which both enables are 0.
- R5: `hs_en` never rises unless both enables have been 0 for at least `DEAD_CYC` preceding cycles.
- R6: `hs_en` and `ls_en` are never 1 in the same cycle.
- R7: A trip sampled while `hs_en` is 0 has no effect. Only the first trip in a switching cycle acts; a second trip in the same cycle changes nothing.
- R8: Maximum duty limit. A switching pulse sampled while `hs_en` is 1 turns the high side off and starts a fresh leading dead interval of `DEAD_CYC` cycles, after which `hs_en` rises again and `ls_en` stays 0. The same happens when a trip and a switching pulse are sampled in the same cycle.
- R9: A switching pulse that arrives during the trailing dead interval (the gap between high-side off and low-side on) cancels the low-side turn-on and starts a fresh leading dead interval. A switching pulse during the leading dead interval is ignored.
- R10: When `fault` is 1 or `enable` is 0 at a clock edge, both enables are 0 after that edge. They stay 0 until `fault` is 0, `enable` is 1 and a new switching pulse is sampled. Switching pulses that arrive while halted are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_tick | input | 1 | One-cycle switching-clock pulse that starts a power cycle |
| trip | input | 1 | PWM comparator trip pulse that ends the high-side on-time |
| enable | input | 1 | Run enable; 0 halts switching |
| fault | input | 1 | Fault / shutdown request; 1 halts switching |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
In the high-side phase, a switching pulse and a comparator trip can both be sampled on the same edge, which is where the maximum-duty limit and normal termination meet. The bench creates this case by placing a trip exactly on the pulse cycle of a period that had no earlier trip. It expects the new leading dead interval to start with the low side held off, and the behavioural model compares both enables on every cycle. The same comparison covers a switching pulse arriving at the last cycle of the trailing dead interval, where the low-side turn-on and the start of a new cycle compete, and a pulse that falls inside the leading dead interval.

// File: rtl/pwm_drv_pkg.sv
package pwm_drv_pkg;

    localparam int unsigned SW_SLOW_HZ = 300_000;
    localparam int unsigned SW_FAST_HZ = 600_000;

    // Phase of the switching cycle; both enables are low except in HIGH/LOW
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LEAD  = 3'd1,
        PH_HIGH  = 3'd2,
        PH_TRAIL = 3'd3,
        PH_LOW   = 3'd4
    } phase_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    typedef struct packed {
        logic tick;
        logic trip;
        logic halt;
    } evt_t;

    // System-clock cycles per switching period for the selected rate
    function automatic int unsigned sw_period_cycles(input int unsigned sys_hz,
                                                     input logic fast);
        return sys_hz / (fast ? SW_FAST_HZ : SW_SLOW_HZ);
    endfunction

    function automatic logic in_dead(input phase_e p);
        return (p == PH_LEAD) || (p == PH_TRAIL);
    endfunction

endpackage

// File: rtl/pwm_dead_timer.sv
module pwm_dead_timer #(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    output logic expired
);
    localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || !active) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = active && (cnt_q == LAST);
endmodule

// File: rtl/pwm_phase_fsm.sv
module pwm_phase_fsm
    import pwm_drv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  evt_t   evt,
    input  logic   expired,
    output phase_e cur,
    output phase_e nxt
);
    phase_e cur_q;

    always_comb begin
        nxt = cur_q;
        if (evt.halt) begin
            nxt = PH_IDLE;
        end else begin
            unique case (cur_q)
                PH_IDLE:  if (evt.tick) nxt = PH_LEAD;
                PH_LEAD:  if (expired)  nxt = PH_HIGH;
                PH_HIGH: begin
                    if (evt.tick)       nxt = PH_LEAD;
                    else if (evt.trip)  nxt = PH_TRAIL;
                end
                PH_TRAIL: begin
                    if (evt.tick)       nxt = PH_LEAD;
                    else if (expired)   nxt = PH_LOW;
                end
                PH_LOW:   if (evt.tick) nxt = PH_LEAD;
                default:                nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= PH_IDLE;
        else     cur_q <= nxt;
    end

    assign cur = cur_q;
endmodule

// File: rtl/pwm_gate_decode.sv
module pwm_gate_decode
    import pwm_drv_pkg::*;
(
    input  phase_e ph,
    output gate_t  gate
);
    always_comb begin
        gate.hs = (ph == PH_HIGH);
        gate.ls = (ph == PH_LOW);
    end
endmodule

// File: rtl/pwm_nonoverlap_drv.sv
module pwm_nonoverlap_drv
    import pwm_drv_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_tick,
    input  logic trip,
    input  logic enable,
    input  logic fault,
    output logic hs_en,
    output logic ls_en
);
    evt_t   evt;
    phase_e ph_cur;
    phase_e ph_nxt;
    logic   dead_expired;
    gate_t  gate;

    always_comb begin
        evt.tick = sw_tick;
        evt.trip = trip;
        evt.halt = fault || !enable;
    end

    pwm_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (in_dead(ph_cur)),
        .restart (ph_nxt != ph_cur),
        .expired (dead_expired)
    );

    pwm_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .expired (dead_expired),
        .cur     (ph_cur),
        .nxt     (ph_nxt)
    );

    pwm_gate_decode u_dec (
        .ph   (ph_cur),
        .gate (gate)
    );

    assign hs_en = gate.hs;
    assign ls_en = gate.ls;
endmodule

// File: rtl/pwm_drv_checker.sv
module pwm_drv_checker #(
    parameter int DEAD_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic sw_tick,
    input logic trip,
    input logic enable,
    input logic fault,
    input logic hs_en,
    input logic ls_en
);
    localparam int RUN_W = $clog2(DEAD_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEAD_CYC + 1);
    localparam logic [RUN_W-1:0] DT_V    = RUN_W'(DEAD_CYC);

    // Consecutive cycles with both enables low, saturating above DEAD_CYC
    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                      low_run <= '0;
        else if (hs_en || ls_en)      low_run <= '0;
        else if (low_run != RUN_MAX)  low_run <= low_run + 1'b1;
    end

    AST_NO_CROSS_COND: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en)); // R6

    AST_LS_DEAD_EXACT: assert property (@(posedge clk) disable iff (rst)
        (ls_en && !$past(ls_en)) |-> (low_run == DT_V)); // R4

    AST_HS_DEAD_MIN: assert property (@(posedge clk) disable iff (rst)
        (hs_en && !$past(hs_en)) |-> (low_run >= DT_V)); // R5

    AST_HALT_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        (fault || !enable) |=> (!hs_en && !ls_en)); // R10

    AST_TRIP_ENDS_HS: assert property (@(posedge clk) disable iff (rst)
        (hs_en && trip) |=> !hs_en); // R3

    AST_HS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (hs_en && !trip && !sw_tick && enable && !fault) |=> hs_en); // R3
endmodule

bind pwm_nonoverlap_drv pwm_drv_checker #(.DEAD_CYC(DEAD_CYC)) u_pwm_drv_checker (
    .clk     (clk),
    .rst     (rst),
    .sw_tick (sw_tick),
    .trip    (trip),
    .enable  (enable),
    .fault   (fault),
    .hs_en   (hs_en),
    .ls_en   (ls_en)
);

// File: tb/pwm_nonoverlap_drv_bench.sv
module pwm_nonoverlap_drv_bench;
    import pwm_drv_pkg::*;

    localparam int DT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_tick = 1'b0;
    logic trip = 1'b0;
    logic enable = 1'b0;
    logic fault = 1'b0;
    logic hs_en;
    logic ls_en;

    always #5 clk = ~clk;

    pwm_nonoverlap_drv #(.DEAD_CYC(DT)) u_pwm_nonoverlap_drv (
        .clk     (clk),
        .rst     (rst),
        .sw_tick (sw_tick),
        .trip    (trip),
        .enable  (enable),
        .fault   (fault),
        .hs_en   (hs_en),
        .ls_en   (ls_en)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string req    = "R1";
    bit    done   = 1'b0;

    // Behavioural reference: expected levels plus countdowns to the next turn-on
    bit m_hs = 1'b0;
    bit m_ls = 1'b0;
    int wait_hs = -1;
    int wait_ls = -1;
    bit started = 1'b0;

    always @(posedge clk) begin
        started = 1'b1;
        if (rst || fault || !enable) begin
            m_hs = 1'b0; m_ls = 1'b0; wait_hs = -1; wait_ls = -1;
        end else if (sw_tick && wait_hs < 0) begin
            m_hs = 1'b0; m_ls = 1'b0; wait_ls = -1; wait_hs = DT;
        end else if (wait_hs > 0) begin
            wait_hs = wait_hs - 1;
            if (wait_hs == 0) begin m_hs = 1'b1; wait_hs = -1; end
        end else if (m_hs && trip) begin
            m_hs = 1'b0; wait_ls = DT;
        end else if (wait_ls > 0) begin
            wait_ls = wait_ls - 1;
            if (wait_ls == 0) begin m_ls = 1'b1; wait_ls = -1; end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_chk++;
            if (hs_en !== m_hs || ls_en !== m_ls) begin
                n_fail++;
                $display("FAIL %s at %0t: hs/ls actual %b%b expected %b%b",
                         req, $time, hs_en, ls_en, m_hs, m_ls);
            end
            n_chk++;
            if (hs_en === 1'b1 && ls_en === 1'b1) begin
                n_fail++;
                $display("FAIL R6 at %0t: both enables high, actual 11 expected not 11", $time);
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sw_tick = 1'b0;
            trip    = 1'b0;
        end
    endtask

    // One switching period: pulse at offset 0 (and optionally xt), trips at t1/t2
    task automatic drive(input int period, input int t1, input int t2, input int xt);
        for (int i = 0; i < period; i++) begin
            @(negedge clk);
            sw_tick = (i == 0) || (i == xt);
            trip    = (i == t1) || (i == t2);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog for %s: actual hung expected finished", req);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset and idle without pulses
        req = "R1";
        repeat (4) @(negedge clk);
        rst = 1'b0;
        enable = 1'b1;
        idle(6);

        // R2 / R3 / R4 / R5: normal trip-terminated cycles
        req = "R2"; drive(40, 15, -1, -1);
        req = "R3"; drive(40, 20, -1, -1);
        req = "R4"; drive(40, 10, -1, -1);
        req = "R5"; drive(30, 25, -1, -1);

        // R7: trip during leading dead time, and a second trip in the low phase
        req = "R7"; drive(40, 1, 15, -1);
        req = "R7"; drive(40, 10, 22, -1);
        req = "R7"; drive(40, 30, 31, -1);

        // R8: no trip (max duty), then pulse and trip coinciding
        req = "R8"; drive(20, -1, -1, -1);
        req = "R8"; drive(20, -1, -1, -1);
        req = "R8"; drive(20, 0, 10, -1);

        // R9: pulse lands in trailing dead time; pulse inside leading dead time
        req = "R9"; drive(20, 17, -1, -1);
        req = "R9"; drive(20, 18, -1, -1);
        req = "R9"; drive(20, 8, -1, 1);
        req = "R9"; drive(20, 8, -1, 2);

        // R10: fault during high side, pulse while halted, release
        req = "R10";
        drive(8, -1, -1, -1);
        @(negedge clk); fault = 1'b1; sw_tick = 1'b0;
        idle(3);
        @(negedge clk); sw_tick = 1'b1;
        @(negedge clk); sw_tick = 1'b0;
        idle(3);
        @(negedge clk); fault = 1'b0;
        idle(6);
        drive(30, 12, -1, -1);
        // R10: disable during low side
        drive(20, 6, -1, -1);
        @(negedge clk); enable = 1'b0; sw_tick = 1'b0; trip = 1'b0;
        drive(10, 3, -1, -1);
        @(negedge clk); enable = 1'b1; sw_tick = 1'b0; trip = 1'b0;
        idle(5);
        drive(30, 12, -1, -1);

        // R2: switching at the two rates derived from the package
        req = "R2";
        for (int k = 0; k < 3; k++)
            drive(int'(sw_period_cycles(100_000_000, 1'b1)), 60 + 10 * k, -1, -1);
        for (int k = 0; k < 3; k++)
            drive(int'(sw_period_cycles(100_000_000, 1'b0)), 150 + 40 * k, -1, -1);
        idle(10);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule